// File: doc/BRIEF.md
# Serial DAC Input Register and Latch

This block is the digital front end of a 12-bit voltage-output converter. An external host frames a transfer by pulling an active-low frame select, toggles a serial clock and presents serial data; a separate active-low load strobe decides when the received value reaches the converter. All four pins are asynchronous to the block. Each pin passes through a two-stage synchronizer and an edge detector in the fast system clock domain. Everything after that is ordinary synchronous logic.

A frame carries sixteen bits. The first four are padding and the last twelve are the two's complement sample, sent most significant bit first. A bit counter shuts the shift path after the sixteenth bit, so the host may run a free-running clock or a burst. The level of the load pin when the frame opens picks one of two update modes. In the automatic mode the latch takes the word on the sixteenth bit. In the strobed mode it waits for a falling load edge, which lets several converters change together. The latch value is also presented as the ideal signed output in LSB units, where one LSB is 5 V/2048.

Top module: `serial_dac_frontend`

## Requirements
- R1: After reset the latch holds 0, the update strobe is low and the signed output is 0.
- R2: A falling edge on `fs_n` opens a frame. While the frame is open, each falling edge of `sck` shifts `sdi` in. Bit 15 is sent first and bit 0 last. Bits 15..12 are discarded and bits 11..0 form the latch word.
- R3: Once sixteen bits are in, further `sck` falling edges change nothing until the next frame opens.
- R4: If `ld_n` is low when the frame opens, the mode is automatic. The latch then loads on the sixteenth `sck` falling edge.
- R5: If `ld_n` is high when the frame opens, the mode is strobed. The latch then loads on the first `ld_n` falling edge after the sixteenth bit, whether or not `fs_n` has risen. Any further `ld_n` falling edge before a new full word leaves the latch unchanged.
- R6: In the strobed mode, an `ld_n` falling edge that comes before the sixteenth bit does not update the latch.
- R7: If `fs_n` rises before sixteen bits are in, the partial word is dropped and no update occurs, in either mode.
- R8: Every latch load raises `latch_upd` for exactly one clock cycle, and `latch_upd` is never high otherwise.
- R9: `out_lsb` is the latch word read as 12-bit two's complement, spanning -2048 (code 0x800) to +2047 (code 0x7FF).
- R10: A load shows up on `latch_code` and `latch_upd` at the third rising `clk` edge after the pin transition that triggers it.
- R11: Shifting a new word in leaves `latch_code` unchanged until a load occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fs_n | input | 1 | Frame select pin, active low, asynchronous |
| sck | input | 1 | Serial clock pin; data shifts on its falling edge |
| sdi | input | 1 | Serial data pin |
| ld_n | input | 1 | Load strobe pin, active low; its level at frame start selects the mode |
| latch_code | output | 12 | Current latch word |
| latch_upd | output | 1 | One-cycle pulse on each latch load |
| out_lsb | output | 12 | Latch word as a signed value in LSB units |

## Verification
Each pin edge takes two clock edges to cross the synchronizer and become an event. The resulting load lands on `latch_code` and `latch_upd` at the third rising edge after the pin moved, and `out_lsb` follows in the same cycle. The bench reference model gives every driven pin sample the same two-edge delay before acting on it, and compares all three outputs at each falling clock edge, half a cycle after they settle. A directed check on the last bit of an automatic frame samples `latch_upd` after the second and after the third rising edge, and expects low and then high. The bench drives pins only on falling edges and holds each level for at least three cycles, so every pin edge becomes exactly one event.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

  // Update mode latched when a frame opens
  typedef enum logic {
    MODE_AUTO   = 1'b0,
    MODE_STROBE = 1'b1
  } upd_mode_e;

  // Lane order inside the pin synchronizer bank
  localparam int LANE_FS  = 0;
  localparam int LANE_SCK = 1;
  localparam int LANE_SDI = 2;
  localparam int LANE_LD  = 3;
  localparam int N_LANES  = 4;

endpackage

// File: rtl/sdac_pin_sync.sv
module sdac_pin_sync #(
  parameter int            N    = 4,
  parameter int            DEPTH = 2,
  parameter logic [N-1:0]  IDLE = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] fall_o,
  output logic [N-1:0] rise_o
);

  localparam int CHAIN = DEPTH + 1;

  for (genvar g = 0; g < N; g++) begin : g_lane
    logic [CHAIN-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {CHAIN{IDLE[g]}};
      else        chain <= {chain[CHAIN-2:0], pin_i[g]};
    end

    assign lvl_o[g]  = chain[DEPTH-1];
    assign fall_o[g] =  chain[CHAIN-1] & ~chain[DEPTH-1];
    assign rise_o[g] = ~chain[CHAIN-1] &  chain[DEPTH-1];
  end

endmodule

// File: rtl/sdac_shift_ctrl.sv
module sdac_shift_ctrl
  import sdac_pkg::*;
#(
  parameter int WORD_BITS = 16,
  parameter int DATA_BITS = 12,
  localparam int CNT_W    = $clog2(WORD_BITS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fs_fall,
  input  logic                 fs_rise,
  input  logic                 sck_fall,
  input  logic                 sdi_lvl,
  input  logic                 ld_lvl,
  output upd_mode_e            mode_o,
  output logic [CNT_W-1:0]     cnt_o,
  output logic [WORD_BITS-1:0] word_o,
  output logic [DATA_BITS-1:0] next_data_o,
  output logic                 word_done_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_BITS - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_BITS);

  logic                 active;
  logic                 shift_en;
  logic [WORD_BITS-1:0] word_next;

  assign shift_en    = sck_fall && active && (cnt_o < FULL) && !fs_fall && !fs_rise;
  assign word_next   = {word_o[WORD_BITS-2:0], sdi_lvl};
  assign next_data_o = word_next[DATA_BITS-1:0];
  assign word_done_o = shift_en && (cnt_o == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt_o  <= '0;
      word_o <= '0;
      mode_o <= MODE_AUTO;
    end else if (fs_fall) begin
      active <= 1'b1;
      cnt_o  <= '0;
      mode_o <= ld_lvl ? MODE_STROBE : MODE_AUTO;
    end else if (fs_rise) begin
      active <= 1'b0;
    end else if (shift_en) begin
      word_o <= word_next;
      cnt_o  <= cnt_o + 1'b1;
    end
  end

endmodule

// File: rtl/sdac_latch.sv
module sdac_latch
  import sdac_pkg::*;
#(
  parameter int DATA_BITS = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  upd_mode_e            mode,
  input  logic                 word_done,
  input  logic                 fs_fall,
  input  logic                 ld_fall,
  input  logic [DATA_BITS-1:0] next_data,
  input  logic [DATA_BITS-1:0] held_data,
  output logic [DATA_BITS-1:0] code_o,
  output logic                 upd_o
);

  logic ready;
  logic load_auto;
  logic load_strobe;

  assign load_auto   = word_done && (mode == MODE_AUTO);
  assign load_strobe = ld_fall && ready && !fs_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 ready <= 1'b0;
    else if (fs_fall)                           ready <= 1'b0;
    else if (word_done && mode == MODE_STROBE)  ready <= 1'b1;
    else if (load_strobe)                       ready <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_o <= '0;
      upd_o  <= 1'b0;
    end else begin
      upd_o <= load_auto || load_strobe;
      if (load_auto)        code_o <= next_data;
      else if (load_strobe) code_o <= held_data;
    end
  end

endmodule

// File: rtl/serial_dac_frontend.sv
module serial_dac_frontend
  import sdac_pkg::*;
#(
  parameter int WORD_BITS  = 16,
  parameter int DATA_BITS  = 12,
  parameter int SYNC_DEPTH = 2,
  localparam int CNT_W     = $clog2(WORD_BITS + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        fs_n,
  input  logic                        sck,
  input  logic                        sdi,
  input  logic                        ld_n,
  output logic [DATA_BITS-1:0]        latch_code,
  output logic                        latch_upd,
  output logic signed [DATA_BITS-1:0] out_lsb
);

  // Ideal output in LSB units: the code read as two's complement
  function automatic logic signed [DATA_BITS-1:0] code_to_lsb(input logic [DATA_BITS-1:0] c);
    return $signed(c);
  endfunction

  localparam logic [N_LANES-1:0] PIN_IDLE = N_LANES'(
      (1 << LANE_FS) | (1 << LANE_SCK) | (1 << LANE_LD));

  logic [N_LANES-1:0] pins, lvl, fall, rise;

  // Named events brought out for the checker
  logic                 fs_fall_ev, fs_rise_ev, sck_fall_ev, ld_fall_ev;
  logic                 word_done_ev;
  logic                 auto_mode;
  upd_mode_e            mode;
  logic [CNT_W-1:0]     bit_cnt;
  logic [WORD_BITS-1:0] shift_word;
  logic [DATA_BITS-1:0] next_data;

  always_comb begin
    pins           = '0;
    pins[LANE_FS]  = fs_n;
    pins[LANE_SCK] = sck;
    pins[LANE_SDI] = sdi;
    pins[LANE_LD]  = ld_n;
  end

  sdac_pin_sync #(
    .N    (N_LANES),
    .DEPTH(SYNC_DEPTH),
    .IDLE (PIN_IDLE)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_i (pins),
    .lvl_o (lvl),
    .fall_o(fall),
    .rise_o(rise)
  );

  assign fs_fall_ev  = fall[LANE_FS];
  assign fs_rise_ev  = rise[LANE_FS];
  assign sck_fall_ev = fall[LANE_SCK];
  assign ld_fall_ev  = fall[LANE_LD];
  assign auto_mode   = (mode == MODE_AUTO);

  sdac_shift_ctrl #(
    .WORD_BITS(WORD_BITS),
    .DATA_BITS(DATA_BITS)
  ) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .fs_fall    (fs_fall_ev),
    .fs_rise    (fs_rise_ev),
    .sck_fall   (sck_fall_ev),
    .sdi_lvl    (lvl[LANE_SDI]),
    .ld_lvl     (lvl[LANE_LD]),
    .mode_o     (mode),
    .cnt_o      (bit_cnt),
    .word_o     (shift_word),
    .next_data_o(next_data),
    .word_done_o(word_done_ev)
  );

  sdac_latch #(
    .DATA_BITS(DATA_BITS)
  ) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .word_done(word_done_ev),
    .fs_fall  (fs_fall_ev),
    .ld_fall  (ld_fall_ev),
    .next_data(next_data),
    .held_data(shift_word[DATA_BITS-1:0]),
    .code_o   (latch_code),
    .upd_o    (latch_upd)
  );

  assign out_lsb = code_to_lsb(latch_code);

endmodule

// File: rtl/sdac_checker.sv
module sdac_checker #(
  parameter int WORD_BITS = 16,
  parameter int DATA_BITS = 12,
  localparam int CNT_W    = $clog2(WORD_BITS + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [DATA_BITS-1:0] latch_code,
  input logic                 latch_upd,
  input logic                 auto_mode,
  input logic [CNT_W-1:0]     bit_cnt,
  input logic                 sck_fall_ev,
  input logic                 ld_fall_ev,
  input logic                 fs_fall_ev,
  input logic [WORD_BITS-1:0] shift_word
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_BITS);

  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= FULL);

  a_r3_lockout: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_fall_ev && bit_cnt == FULL && !fs_fall_ev) |=> $stable(shift_word));

  a_r4_auto_on_sck: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_upd && auto_mode) |-> $past(sck_fall_ev));

  a_r5_strobe_on_ld: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_upd && !auto_mode) |-> $past(ld_fall_ev));

  a_r7_full_word_only: assert property (@(posedge clk) disable iff (!rst_n)
    latch_upd |-> bit_cnt == FULL);

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    latch_upd |=> !latch_upd);

  a_r11_hold_between_loads: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(latch_code) |-> latch_upd);

endmodule

bind serial_dac_frontend sdac_checker #(
  .WORD_BITS(WORD_BITS),
  .DATA_BITS(DATA_BITS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .latch_code (latch_code),
  .latch_upd  (latch_upd),
  .auto_mode  (auto_mode),
  .bit_cnt    (bit_cnt),
  .sck_fall_ev(sck_fall_ev),
  .ld_fall_ev (ld_fall_ev),
  .fs_fall_ev (fs_fall_ev),
  .shift_word (shift_word)
);

// File: tb/serial_dac_frontend_bench.sv
`timescale 1ns/1ps
module serial_dac_frontend_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fs_n = 1'b1, sck = 1'b1, sdi = 1'b0, ld_n = 1'b1;
  logic [11:0]        latch_code;
  logic               latch_upd;
  logic signed [11:0] out_lsb;

  int n_checks = 0, n_errors = 0, n_upd = 0, cyc = 0;

  always #2 clk = ~clk;  // 250 MHz

  serial_dac_frontend u_serial_dac_frontend (
    .clk(clk), .rst_n(rst_n), .fs_n(fs_n), .sck(sck), .sdi(sdi), .ld_n(ld_n),
    .latch_code(latch_code), .latch_upd(latch_upd), .out_lsb(out_lsb)
  );

  task automatic check(input string tag, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic int as_signed12(input int c);
    return (c >= 2048) ? c - 4096 : c;
  endfunction

  // Behavioural reference: pin samples wait in a queue two edges, then act
  bit q_fs[$], q_sck[$], q_sdi[$], q_ld[$];
  bit m_open, m_strobe, m_ready, m_upd;
  int m_cnt, m_word, m_latch;

  always @(posedge clk) begin
    if (!rst_n) begin
      q_fs = {1'b1, 1'b1, 1'b1}; q_sck = {1'b1, 1'b1, 1'b1};
      q_sdi = {1'b0, 1'b0, 1'b0}; q_ld = {1'b1, 1'b1, 1'b1};
      m_open = 0; m_strobe = 0; m_ready = 0; m_upd = 0;
      m_cnt = 0; m_word = 0; m_latch = 0;
    end else begin
      bit fs_dn, fs_up, sck_dn, ld_dn, d, ld_lv;
      fs_dn  = q_fs[0] && !q_fs[1];
      fs_up  = !q_fs[0] && q_fs[1];
      sck_dn = q_sck[0] && !q_sck[1];
      ld_dn  = q_ld[0] && !q_ld[1];
      d      = q_sdi[1];
      ld_lv  = q_ld[1];
      m_upd  = 0;
      if (!fs_dn && ld_dn && m_ready) begin
        m_latch = m_word & 12'hFFF; m_upd = 1; m_ready = 0;
      end
      if (fs_dn) begin
        m_open = 1; m_cnt = 0; m_strobe = ld_lv; m_ready = 0;
      end else if (fs_up) begin
        m_open = 0;
      end else if (sck_dn && m_open && m_cnt < 16) begin
        m_word = ((m_word << 1) | int'(d)) & 16'hFFFF;
        m_cnt++;
        if (m_cnt == 16) begin
          if (m_strobe) m_ready = 1;
          else begin m_latch = m_word & 12'hFFF; m_upd = 1; end
        end
      end
      void'(q_fs.pop_front()); void'(q_sck.pop_front());
      void'(q_sdi.pop_front()); void'(q_ld.pop_front());
      q_fs.push_back(fs_n); q_sck.push_back(sck);
      q_sdi.push_back(sdi); q_ld.push_back(ld_n);
    end
  end

  // Every-cycle comparison against the model (R10 timing, R9 conversion)
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      check("R10 latch_code vs model", latch_code, m_latch);
      check("R8 latch_upd vs model", latch_upd, m_upd);
      check("R9 out_lsb vs model", out_lsb, as_signed12(m_latch));
      if (latch_upd) n_upd++;
    end
  end

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One frame: strobe picks ld_n level at frame start; early_ld inserts an
  // ld_n pulse after that bit index; lat_chk probes the 16th-bit timing.
  task automatic frame(input bit strobe, input logic [15:0] w, input int nbits,
                       input int extra, input int early_ld, input bit lat_chk);
    ld_n = strobe; wcyc(4);
    fs_n = 1'b0;   wcyc(4);
    for (int i = 0; i < nbits + extra; i++) begin
      sdi = (i < nbits) ? w[15-i] : 1'b1;
      wcyc(3);
      sck = 1'b0;
      if (lat_chk && i == 15) begin
        repeat (2) @(posedge clk);
        #1 check("R10 no update after two edges", latch_upd, 0);
        @(posedge clk);
        #1 check("R10 update on third edge", latch_upd, 1);
        @(negedge clk);
        wcyc(2);
      end else wcyc(3);
      sck = 1'b1; wcyc(2);
      if (early_ld == i) begin
        ld_n = 1'b0; wcyc(4); ld_n = 1'b1; wcyc(4);
      end
    end
    fs_n = 1'b1; wcyc(4);
    ld_n = 1'b1; wcyc(4);
  endtask

  task automatic ld_pulse();
    ld_n = 1'b0; wcyc(5); ld_n = 1'b1; wcyc(5);
  endtask

  initial begin
    int base;
    wcyc(5);
    check("R1 reset latch", latch_code, 0);
    check("R1 reset strobe", latch_upd, 0);
    check("R1 reset out", out_lsb, 0);
    rst_n = 1'b1;
    wcyc(4);
    check("R1 idle latch", latch_code, 0);

    // R2 R4: automatic, padding bits set, largest positive code
    base = n_upd;
    frame(1'b0, 16'hF7FF, 16, 0, -1, 1'b1);
    check("R2 R4 auto load", latch_code, 12'h7FF);
    check("R9 full positive", out_lsb, 2047);
    check("R8 one strobe per load", n_upd - base, 1);

    // R9: most negative code
    frame(1'b0, 16'h0800, 16, 0, -1, 1'b0);
    check("R9 full negative", out_lsb, -2048);

    // R3: extra clocks with sdi high after sixteen bits
    base = n_upd;
    frame(1'b0, 16'hA123, 16, 5, -1, 1'b0);
    check("R3 extra clocks ignored", latch_code, 12'h123);
    check("R3 single strobe", n_upd - base, 1);

    // R5 R6 R11: strobed, early ld pulse mid-frame
    base = n_upd;
    frame(1'b1, 16'h0ABC, 16, 0, 7, 1'b0);
    check("R6 early ld ignored", n_upd - base, 0);
    check("R11 latch holds after shift", latch_code, 12'h123);
    ld_pulse();
    check("R5 strobed load", latch_code, 12'hABC);
    check("R5 one strobe", n_upd - base, 1);
    ld_pulse();
    check("R5 second ld ignored", n_upd - base, 1);

    // R7: partial frames in both modes
    base = n_upd;
    frame(1'b0, 16'h0555, 10, 0, -1, 1'b0);
    check("R7 auto partial dropped", latch_code, 12'hABC);
    frame(1'b1, 16'h0555, 12, 0, -1, 1'b0);
    ld_pulse();
    check("R7 strobed partial dropped", latch_code, 12'hABC);
    check("R7 no strobe", n_upd - base, 0);

    // R2: alternating pattern, then a negative mid value
    frame(1'b0, 16'h5A5A, 16, 0, -1, 1'b0);
    check("R2 pattern", latch_code, 12'hA5A);
    check("R9 negative value", out_lsb, -1446);

    wcyc(5);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule